// File: doc/BRIEF.md
# Triggered Four-Channel Sample Readout Sequencer

This block fetches one conversion result from a converter that presents all of its channels, one after another, on a single serial data line. A request carries a channel index. The block raises a conversion trigger line for a fixed number of local clock cycles. It then waits a short settling gap and runs a serial clock over the complete frame. The word of the requested channel is kept and the other three are dropped. The kept word is returned both as a raw 24-bit value and as a 32-bit two's-complement value with its sign extended.

The trigger must stay high for a minimum time. That minimum is three of the converter's internal digital clock periods, and each of those is two converter system clock periods. The block derives the high time from the converter system clock frequency and the local clock period, and rounds up. The whole frame is always clocked out, because a short transfer would make the converter report an incomplete read. An index outside the channel range is refused with a one-cycle error pulse. A request that arrives while a readout is in progress is dropped.

Top module: `adc_frame_rdo`

## Requirements
- R1: A request with index 0 to 3, made while idle, drives `odr_o` high on the next cycle. It stays high for exactly ceil(ceil(6 converter clock periods in ns) / local period) cycles, which is 13 cycles at the defaults (48 MHz, 10 ns).
- R2: `cs_n_o` goes low only after `odr_o` has fallen, and `odr_o` is never high while `cs_n_o` is low.
- R3: Each readout produces exactly 96 rising edges of `sclk_o` while `cs_n_o` is low. `sclk_o` idles low, and every half period of `sclk_o` lasts SCK_HALF local cycles (2 at the defaults).
- R4: The frame is sampled on rising `sclk_o` edges. Channel 0 comes first and channel 3 last, and each 24-bit word arrives most significant bit first. `rd_word_o` equals the word at the requested index.
- R5: `rd_valid_o` is high for exactly one cycle per accepted request, one cycle after the last falling edge of `sclk_o`. The output words hold their value until the next `rd_valid_o`.
- R6: `rd_word_sx_o` equals `rd_word_o` with bit 23 copied into bits 31 to 24.
- R7: A request made while `busy_o` is high is ignored, whatever its index. It causes no error pulse and does not change the channel that is returned.
- R8: A request with an index above 3, made while idle, gives a one-cycle `err_o` pulse on the next cycle. It raises neither `odr_o` nor `busy_o`.
- R9: After reset, `odr_o`=0, `cs_n_o`=1, `sclk_o`=0, `busy_o`=0, `err_o`=0, `rd_valid_o`=0, and both output words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Readout request strobe |
| req_chan_i | input | 3 | Requested channel index |
| odr_o | output | 1 | Conversion trigger pulse |
| cs_n_o | output | 1 | Serial chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial frame data from the converter |
| busy_o | output | 1 | Readout in progress |
| err_o | output | 1 | Bad channel index pulse |
| rd_valid_o | output | 1 | Result valid pulse |
| rd_word_o | output | 24 | Selected channel word |
| rd_word_sx_o | output | 32 | Selected word, sign-extended |

## Verification
The hardest case to reach from the ports is a second request that lands while the sequencer is part-way through a frame, because the block gives no sign of which phase it is in. The bench makes this case by raising a request in the middle of the trigger phase and another in the middle of the shifting phase. One of these carries a different valid index and the other an out-of-range index. The scoreboard then confirms that only the first channel's word comes back and that no error pulse appears. A behavioural converter model drives a distinct word per channel, including words at the sign boundaries, so that a wrong channel or a wrong bit order shows up as a mismatch.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TRIG  = 2'd1,
      ST_SETTLE = 2'd2,
      ST_SHIFT = 2'd3
   } rdo_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int min_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rdo_odr_pulse.sv
module rdo_odr_pulse #(
   parameter int HIGH_CYC = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic odr_o,
   output logic done_o
);
   localparam int CNT_W = $clog2(HIGH_CYC + 1);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         odr_o    <= 1'b0;
         done_o   <= 1'b0;
         remain_q <= '0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !odr_o) begin
            odr_o    <= 1'b1;
            remain_q <= CNT_W'(HIGH_CYC - 1);
         end else if (odr_o) begin
            if (remain_q == '0) begin
               odr_o  <= 1'b0;
               done_o <= 1'b1;
            end else begin
               remain_q <= remain_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rdo_frame_shift.sv
module rdo_frame_shift #(
   parameter int NUM_CH   = 4,
   parameter int WORD_W   = 24,
   parameter int SCK_HALF = 2,
   localparam int WIDX_W  = rdo_pkg::min_w(NUM_CH),
   localparam int BIDX_W  = rdo_pkg::min_w(WORD_W),
   localparam int HALF_W  = rdo_pkg::min_w(SCK_HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sdi_i,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              bit_stb_o,
   output logic              bit_val_o,
   output logic [WIDX_W-1:0] bit_word_o,
   output logic              done_o
);
   logic              active_q;
   logic [HALF_W-1:0] half_q;
   logic [BIDX_W-1:0] bit_q;
   logic [WIDX_W-1:0] word_q;
   logic              half_end;
   logic              last_bit;

   always_comb begin
      half_end = (half_q == HALF_W'(SCK_HALF - 1));
      last_bit = (bit_q == BIDX_W'(WORD_W - 1)) && (word_q == WIDX_W'(NUM_CH - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         sclk_o     <= 1'b0;
         half_q     <= '0;
         bit_q      <= '0;
         word_q     <= '0;
         bit_stb_o  <= 1'b0;
         bit_val_o  <= 1'b0;
         bit_word_o <= '0;
         done_o     <= 1'b0;
      end else begin
         bit_stb_o <= 1'b0;
         done_o    <= 1'b0;
         if (start_i && !active_q) begin
            active_q <= 1'b1;
            sclk_o   <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
            word_q   <= '0;
         end else if (active_q) begin
            if (!half_end) begin
               half_q <= half_q + 1'b1;
            end else begin
               half_q <= '0;
               sclk_o <= ~sclk_o;
               if (!sclk_o) begin
                  bit_stb_o  <= 1'b1;
                  bit_val_o  <= sdi_i;
                  bit_word_o <= word_q;
               end else if (last_bit) begin
                  active_q <= 1'b0;
                  done_o   <= 1'b1;
               end else if (bit_q == BIDX_W'(WORD_W - 1)) begin
                  bit_q  <= '0;
                  word_q <= word_q + 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign cs_n_o = ~active_q;
endmodule

// File: rtl/rdo_word_pick.sv
module rdo_word_pick #(
   parameter int NUM_CH     = 4,
   parameter int WORD_W     = 24,
   parameter int OUT_W      = 32,
   parameter bit SIGNED_OUT = 1'b1,
   localparam int WIDX_W    = rdo_pkg::min_w(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic [WIDX_W-1:0] sel_i,
   input  logic              bit_stb_i,
   input  logic              bit_val_i,
   input  logic [WIDX_W-1:0] bit_word_i,
   input  logic              done_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] word_o,
   output logic [OUT_W-1:0]  word_ext_o
);
   logic [WORD_W-1:0] acc_q;
   logic [OUT_W-1:0]  ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clear_i) begin
            acc_q <= '0;
         end else if (bit_stb_i && (bit_word_i == sel_i)) begin
            acc_q <= {acc_q[WORD_W-2:0], bit_val_i};
         end
         if (done_i) begin
            word_o  <= acc_q;
            valid_o <= 1'b1;
         end
      end
   end

   generate
      if (OUT_W == WORD_W) begin : g_same
         assign ext = word_o;
      end else if (SIGNED_OUT) begin : g_sext
         assign ext = {{(OUT_W-WORD_W){word_o[WORD_W-1]}}, word_o};
      end else begin : g_zext
         assign ext = {{(OUT_W-WORD_W){1'b0}}, word_o};
      end
   endgenerate

   assign word_ext_o = ext;
endmodule

// File: rtl/adc_frame_rdo.sv
module adc_frame_rdo #(
   parameter int NUM_CH        = 4,
   parameter int WORD_W        = 24,
   parameter int OUT_W         = 32,
   parameter int SEL_W         = 3,
   parameter int SYSCLK_KHZ    = 48000,
   parameter int DIG_HIGH      = 3,
   parameter int CLK_PERIOD_NS = 10,
   parameter int SCK_HALF      = 2,
   parameter int SETTLE_CYC    = 2,
   parameter bit SIGNED_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [SEL_W-1:0]  req_chan_i,
   output logic              odr_o,
   output logic              cs_n_o,
   output logic              sclk_o,
   input  logic              sdi_i,
   output logic              busy_o,
   output logic              err_o,
   output logic              rd_valid_o,
   output logic [WORD_W-1:0] rd_word_o,
   output logic [OUT_W-1:0]  rd_word_sx_o
);
   import rdo_pkg::*;

   localparam int ODR_MIN_NS = ceil_div(DIG_HIGH * 2 * 1000000, SYSCLK_KHZ);
   localparam int ODR_CYC    = ceil_div(ODR_MIN_NS, CLK_PERIOD_NS);
   localparam int WIDX_W     = min_w(NUM_CH);
   localparam int SET_W      = min_w(SETTLE_CYC);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (WORD_W < 2 || WORD_W > OUT_W) begin : g_bad_w
         $error("WORD_W must lie in 2..OUT_W");
      end
      if (SEL_W < WIDX_W) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_CH");
      end
      if (SCK_HALF < 1 || SETTLE_CYC < 1 || ODR_CYC < 1) begin : g_bad_t
         $error("timing parameters must be positive");
      end
   endgenerate

   rdo_state_e        st_q;
   logic [WIDX_W-1:0] sel_q;
   logic [SET_W-1:0]  settle_q;
   logic              chan_ok;
   logic              odr_start;
   logic              shift_start;
   logic              odr_done;
   logic              bit_stb;
   logic              bit_val;
   logic [WIDX_W-1:0] bit_word;
   logic              frame_done;

   always_comb begin
      chan_ok     = ({1'b0, req_chan_i} < (SEL_W+1)'(NUM_CH));
      odr_start   = (st_q == ST_IDLE) && req_valid_i && chan_ok;
      shift_start = (st_q == ST_SETTLE) && (settle_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         sel_q    <= '0;
         settle_q <= '0;
         err_o    <= 1'b0;
      end else begin
         err_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  if (chan_ok) begin
                     sel_q <= req_chan_i[WIDX_W-1:0];
                     st_q  <= ST_TRIG;
                  end else begin
                     err_o <= 1'b1;
                  end
               end
            end
            ST_TRIG: begin
               if (odr_done) begin
                  settle_q <= SET_W'(SETTLE_CYC - 1);
                  st_q     <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_q == '0) st_q <= ST_SHIFT;
               else                settle_q <= settle_q - 1'b1;
            end
            ST_SHIFT: begin
               if (frame_done) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE);

   rdo_odr_pulse #(
      .HIGH_CYC (ODR_CYC)
   ) u_odr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (odr_start),
      .odr_o   (odr_o),
      .done_o  (odr_done)
   );

   rdo_frame_shift #(
      .NUM_CH   (NUM_CH),
      .WORD_W   (WORD_W),
      .SCK_HALF (SCK_HALF)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (shift_start),
      .sdi_i      (sdi_i),
      .cs_n_o     (cs_n_o),
      .sclk_o     (sclk_o),
      .bit_stb_o  (bit_stb),
      .bit_val_o  (bit_val),
      .bit_word_o (bit_word),
      .done_o     (frame_done)
   );

   rdo_word_pick #(
      .NUM_CH     (NUM_CH),
      .WORD_W     (WORD_W),
      .OUT_W      (OUT_W),
      .SIGNED_OUT (SIGNED_OUT)
   ) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (shift_start),
      .sel_i      (sel_q),
      .bit_stb_i  (bit_stb),
      .bit_val_i  (bit_val),
      .bit_word_i (bit_word),
      .done_i     (frame_done),
      .valid_o    (rd_valid_o),
      .word_o     (rd_word_o),
      .word_ext_o (rd_word_sx_o)
   );
endmodule

// File: rtl/rdo_chk.sv
module rdo_chk #(
   parameter int NUM_CH  = 4,
   parameter int SEL_W   = 3,
   parameter int WIDX_W  = 2,
   parameter int ODR_CYC = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid_i,
   input logic [SEL_W-1:0]  req_chan_i,
   input logic              odr_o,
   input logic              cs_n_o,
   input logic              sclk_o,
   input logic              busy_o,
   input logic              err_o,
   input logic              rd_valid_o,
   input logic [WIDX_W-1:0] sel_q
);
   logic [31:0] odr_run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     odr_run_q <= '0;
      else if (odr_o) odr_run_q <= odr_run_q + 1;
      else            odr_run_q <= '0;
   end

   AST_ODR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(odr_o) |-> (odr_run_q == 32'(ODR_CYC))); // R1

   AST_ODR_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      odr_o |-> (odr_run_q < 32'(ODR_CYC))); // R1

   AST_TRIG_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> !odr_o); // R2

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o); // R3

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |=> !rd_valid_o); // R5

   AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && req_valid_i) |=> ($stable(sel_q) && !err_o)); // R7

   AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_valid_i && ({1'b0, req_chan_i} >= (SEL_W+1)'(NUM_CH)))
      |=> (err_o && !odr_o && !busy_o)); // R8
endmodule

bind adc_frame_rdo rdo_chk #(
   .NUM_CH  (NUM_CH),
   .SEL_W   (SEL_W),
   .WIDX_W  (WIDX_W),
   .ODR_CYC (ODR_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .req_chan_i  (req_chan_i),
   .odr_o       (odr_o),
   .cs_n_o      (cs_n_o),
   .sclk_o      (sclk_o),
   .busy_o      (busy_o),
   .err_o       (err_o),
   .rd_valid_o  (rd_valid_o),
   .sel_q       (sel_q)
);

// File: tb/sim_adc_frame_rdo.sv
`timescale 1ns/1ps
module sim_adc_frame_rdo;
   localparam int CLK_PERIOD = 10;
   localparam int EXP_ODR    = 13;  // ceil(ceil(6*1e6/48000 ns)/10 ns)
   localparam int EXP_SCLK   = 96;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_chan = '0;
   logic        odr, cs_n, sclk, sdi, busy, err, rd_valid;
   logic [23:0] rd_word;
   logic [31:0] rd_word_sx;

   int checks = 0;
   int failures = 0;
   int valid_seen = 0;
   int valid_exp = 0;
   bit finished = 1'b0;

   logic [23:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_frame_rdo u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid),
      .req_chan_i   (req_chan),
      .odr_o        (odr),
      .cs_n_o       (cs_n),
      .sclk_o       (sclk),
      .sdi_i        (sdi),
      .busy_o       (busy),
      .err_o        (err),
      .rd_valid_o   (rd_valid),
      .rd_word_o    (rd_word),
      .rd_word_sx_o (rd_word_sx)
   );

   // converter model: channel 0 first, MSB first, next bit after each falling sclk
   logic [95:0] frame = '0;
   int ptr = 0;
   initial sdi = 1'b0;
   always @(negedge cs_n) begin
      ptr = 0;
      sdi = frame[95];
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         ptr = ptr + 1;
         if (ptr < 96) sdi = frame[95-ptr];
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor
   int odr_run = 0, last_odr = 0, sclk_rises = 0, overlap = 0;
   logic sclk_prev = 1'b0;
   logic valid_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (odr) odr_run++;
         else if (odr_run != 0) begin last_odr = odr_run; odr_run = 0; end
         if (odr && !cs_n) overlap++;
         if (!cs_n && sclk && !sclk_prev) sclk_rises++;
         if (rd_valid) begin
            logic [23:0] e;
            valid_seen++;
            check(!valid_prev, "R5 valid width", 1, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected valid", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(rd_word == e, "R4 word", rd_word, e);
               check(rd_word_sx == {{8{e[23]}}, e}, "R6 sign ext", rd_word_sx, {{8{e[23]}}, e});
               check(sclk_rises == EXP_SCLK, "R3 sclk count", sclk_rises, EXP_SCLK);
               check(last_odr == EXP_ODR, "R1 odr width", last_odr, EXP_ODR);
            end
            sclk_rises = 0;
         end
      end
      sclk_prev  = sclk;
      valid_prev = rd_valid;
   end

   task automatic pulse_req(input logic [2:0] ch);
      @(negedge clk);
      req_valid = 1'b1;
      req_chan  = ch;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read(input logic [2:0] ch, input logic [23:0] w0, w1, w2, w3);
      logic [23:0] ws[4];
      ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
      frame = {w0, w1, w2, w3};
      exp_q.push_back(ws[ch[1:0]]);
      valid_exp++;
      pulse_req(ch);
      check(odr && busy, "R1 odr rises next cycle", {odr, busy}, 2'b11);
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!odr && cs_n && !sclk && !busy && !err && !rd_valid &&
            rd_word == 0 && rd_word_sx == 0, "R9 reset state",
            {odr, cs_n, sclk, busy, err, rd_valid}, 6'b010000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_read(3'd0, 24'h123456, 24'hABCDEF, 24'h0F0F0F, 24'hF0F0F0);
      do_read(3'd1, 24'h123456, 24'hABCDEF, 24'h0F0F0F, 24'hF0F0F0);
      do_read(3'd2, 24'h800001, 24'h7FFFFF, 24'hFFFFFF, 24'h000000);
      do_read(3'd3, 24'h800001, 24'h7FFFFF, 24'h5A5A5A, 24'hC3C3C3);
      do_read(3'd1, 24'h000001, 24'h7FFFFF, 24'hFFFFFE, 24'h800000);
      do_read(3'd3, 24'h000001, 24'h7FFFFF, 24'hFFFFFE, 24'h800000);

      // R8: out-of-range indices
      for (int k = 4; k < 8; k++) begin
         pulse_req(3'(k));
         check(err && !odr && !busy, "R8 bad index", {err, odr, busy}, 3'b100);
         @(negedge clk);
         check(!err, "R8 err one cycle", err, 0);
      end

      // R7: requests during a readout are dropped
      frame = {24'h111111, 24'h222222, 24'h333333, 24'h444444};
      exp_q.push_back(24'h222222);
      valid_exp++;
      pulse_req(3'd1);
      repeat (3) @(negedge clk);
      pulse_req(3'd2);
      check(!err && odr, "R7 busy request in trigger phase", {err, odr}, 2'b01);
      while (cs_n) @(negedge clk);
      repeat (40) @(negedge clk);
      pulse_req(3'd6);
      check(!err && busy, "R7 bad index while busy", {err, busy}, 2'b01);
      wait_idle();
      check(rd_word == 24'h222222, "R7 held channel", rd_word, 24'h222222);
      repeat (10) @(negedge clk);
      check(rd_word == 24'h222222, "R5 word held", rd_word, 24'h222222);

      check(overlap == 0, "R2 trigger overlap", overlap, 0);
      check(valid_seen == valid_exp, "R5 valid count", valid_seen, valid_exp);
      check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule